// File: doc/BRIEF.md
# Simple Vectored Interrupt Controller

This block handles interrupts for a small CPU that has one global enable flag and no priority levels. At each instruction-fetch boundary it checks one request line. A request is accepted when the machine is running and the enable flag is set. On acceptance the block records the program counter that was about to be fetched and a 16-bit cause code from the source. It then clears the enable flag, sends the CPU to a vector built from an 8-bit source type, and pulses an acknowledge. In that step the normal fetch is suppressed.

The block also carries out the interrupt-support operations that the CPU decodes and hands over with an opcode:
- return from interrupt (opcode 29): reload the PC from the saved copy and set the enable flag, both in one step;
- enable (opcode 10);
- disable (opcode 11);
- save (opcode 16): copy the cause code and the saved PC out to the register file through two write ports;
- restore (opcode 17): load both from the register file through two read-data inputs.

The CPU supplies the contents of its ra and rb registers on the read-data inputs and steers the write ports to ra and rb. Any arbitration between several interrupt sources happens outside the block.

Top module: `intr_unit`

## Requirements
- R1: An interrupt is accepted in a cycle when `run`, `fetch_start`, `irq_req` and the enable flag `ie` are all 1. In any other cycle where `fetch_start` and `run` are both 1, `fetch_go` is 1 and no entry happens.
- R2: In the cycle where an interrupt is accepted, `fetch_go` is 0.
- R3: One cycle after acceptance, the saved PC equals the `cur_pc` value sampled at acceptance, the cause register equals the sampled `src_info`, and `ie` is 0.
- R4: One cycle after acceptance, `pc_load` is 1 and `new_pc` holds the vector: bits 31..12 are zero, bits 11..4 carry `src_type`, and bits 3..0 are zero.
- R5: `irq_ack` is 1 for exactly the one cycle after acceptance. It is 0 again in the cycle after that.
- R6: With `op_valid` and opcode 29, the next cycle shows `pc_load`=1, `new_pc` equal to the saved PC, and `ie`=1.
- R7: With `op_valid`, opcode 10 sets `ie` and opcode 11 clears `ie`. Either change is visible one cycle later.
- R8: With `op_valid` and opcode 16, the next cycle shows `wr_a_en`=1 with `wr_a_data` = {16 zero bits, cause}, and `wr_b_en`=1 with `wr_b_data` = saved PC.
- R9: With `op_valid` and opcode 17, the cause register loads `rd_a_data[15:0]` and the saved PC loads `rd_b_data`. The upper half of `rd_a_data` is dropped.
- R10: After reset, `ie` is 0, the saved PC and cause register are zero, and `irq_ack`, `pc_load`, `wr_a_en` and `wr_b_en` are 0.
- R11: If acceptance and `op_valid` fall in the same cycle, the entry takes effect and the operation is discarded.
- R12: An `op_valid` with any other opcode changes neither `ie`, the saved PC nor the cause register, and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Machine is running |
| fetch_start | input | 1 | Current step is the start of an instruction fetch |
| irq_req | input | 1 | Interrupt request |
| src_type | input | 8 | Source type used to build the vector |
| src_info | input | 16 | Cause code from the source |
| cur_pc | input | 32 | PC of the instruction about to be fetched |
| op_valid | input | 1 | An interrupt-support opcode is being executed |
| opcode | input | 5 | Opcode of that operation |
| rd_a_data | input | 32 | Contents of register ra |
| rd_b_data | input | 32 | Contents of register rb |
| irq_ack | output | 1 | Acknowledge pulse |
| fetch_go | output | 1 | Normal fetch may proceed this step |
| pc_load | output | 1 | Load `new_pc` into the PC |
| new_pc | output | 32 | PC value to load |
| ie | output | 1 | Interrupt enable flag |
| wr_a_en | output | 1 | Write strobe for register ra |
| wr_a_data | output | 32 | Data for register ra |
| wr_b_en | output | 1 | Write strobe for register rb |
| wr_b_data | output | 32 | Data for register rb |

## Verification
Interrupt entry and the execution of a support operation can fall in the same cycle. The case is provoked by presenting a restore opcode, with distinctive register data, in the very cycle in which a request is accepted at a fetch boundary. The result is judged through a following save. It must return the PC and cause captured at entry, not the restore data, and `ie` must read 0. A second cross-check uses return-from-interrupt while a request is held. The request must not be taken during the return step, and it must be taken at the next fetch boundary once `ie` has risen.

// File: rtl/intr_unit.sv
module intr_unit #(
  parameter int PC_W    = 32,
  parameter int INFO_W  = 16,
  parameter int TYPE_W  = 8,
  parameter int VEC_LSB = 4,
  parameter int OP_W    = 5,
  parameter int OP_RFI  = 29,
  parameter int OP_EN   = 10,
  parameter int OP_DIS  = 11,
  parameter int OP_SAVE = 16,
  parameter int OP_RSTR = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fetch_start,
  input  logic              irq_req,
  input  logic [TYPE_W-1:0] src_type,
  input  logic [INFO_W-1:0] src_info,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [PC_W-1:0]   rd_a_data,
  input  logic [PC_W-1:0]   rd_b_data,
  output logic              irq_ack,
  output logic              fetch_go,
  output logic              pc_load,
  output logic [PC_W-1:0]   new_pc,
  output logic              ie,
  output logic              wr_a_en,
  output logic [PC_W-1:0]   wr_a_data,
  output logic              wr_b_en,
  output logic [PC_W-1:0]   wr_b_data
);
  localparam int VEC_HI = VEC_LSB + TYPE_W;
  localparam int PAD_W  = PC_W - INFO_W;

  logic [PC_W-1:0]   saved_pc;
  logic [INFO_W-1:0] cause;
  logic              take;
  logic [PC_W-1:0]   vector;

  assign take     = run & fetch_start & irq_req & ie;
  assign fetch_go = run & fetch_start & ~take;
  assign vector   = {{(PC_W-VEC_HI){1'b0}}, src_type, {VEC_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie        <= 1'b0;
      saved_pc  <= '0;
      cause     <= '0;
      irq_ack   <= 1'b0;
      pc_load   <= 1'b0;
      new_pc    <= '0;
      wr_a_en   <= 1'b0;
      wr_a_data <= '0;
      wr_b_en   <= 1'b0;
      wr_b_data <= '0;
    end else begin
      irq_ack <= 1'b0;
      pc_load <= 1'b0;
      wr_a_en <= 1'b0;
      wr_b_en <= 1'b0;
      if (take) begin
        saved_pc <= cur_pc;
        cause    <= src_info;
        ie       <= 1'b0;
        new_pc   <= vector;
        pc_load  <= 1'b1;
        irq_ack  <= 1'b1;
      end else if (op_valid) begin
        case (opcode)
          OP_W'(OP_RFI): begin
            new_pc  <= saved_pc;
            pc_load <= 1'b1;
            ie      <= 1'b1;
          end
          OP_W'(OP_EN):  ie <= 1'b1;
          OP_W'(OP_DIS): ie <= 1'b0;
          OP_W'(OP_SAVE): begin
            wr_a_en   <= 1'b1;
            wr_a_data <= {{PAD_W{1'b0}}, cause};
            wr_b_en   <= 1'b1;
            wr_b_data <= saved_pc;
          end
          OP_W'(OP_RSTR): begin
            cause    <= rd_a_data[INFO_W-1:0];
            saved_pc <= rd_b_data;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module intr_unit_chk #(
  parameter int PC_W    = 32,
  parameter int INFO_W  = 16,
  parameter int TYPE_W  = 8,
  parameter int VEC_LSB = 4,
  parameter int OP_W    = 5,
  parameter int OP_RFI  = 29,
  parameter int OP_EN   = 10,
  parameter int OP_DIS  = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            fetch_start,
  input logic            irq_req,
  input logic            op_valid,
  input logic [OP_W-1:0] opcode,
  input logic            irq_ack,
  input logic            fetch_go,
  input logic            pc_load,
  input logic [PC_W-1:0] new_pc,
  input logic            ie,
  input logic            wr_a_en,
  input logic [PC_W-1:0] wr_a_data
);
  localparam int VEC_HI = VEC_LSB + TYPE_W;
  logic acc;
  assign acc = run && fetch_start && irq_req && ie;

  a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (irq_ack && pc_load && !ie));
  a_r2_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !fetch_go);
  a_r4_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (new_pc[VEC_LSB-1:0] == '0 && (new_pc >> VEC_HI) == '0));
  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc && opcode == OP_W'(OP_RFI)) |=> (pc_load && ie));
  a_r7_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc && opcode == OP_W'(OP_EN)) |=> ie);
  a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc && opcode == OP_W'(OP_DIS)) |=> !ie);
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_en |-> (wr_a_data >> INFO_W) == '0);
endmodule

bind intr_unit intr_unit_chk #(
  .PC_W(PC_W), .INFO_W(INFO_W), .TYPE_W(TYPE_W), .VEC_LSB(VEC_LSB),
  .OP_W(OP_W), .OP_RFI(OP_RFI), .OP_EN(OP_EN), .OP_DIS(OP_DIS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fetch_start(fetch_start),
  .irq_req(irq_req), .op_valid(op_valid), .opcode(opcode),
  .irq_ack(irq_ack), .fetch_go(fetch_go), .pc_load(pc_load),
  .new_pc(new_pc), .ie(ie), .wr_a_en(wr_a_en), .wr_a_data(wr_a_data)
);

// File: tb/intr_unit_tb.sv
module intr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, fetch_start, irq_req, op_valid;
  logic [7:0]  src_type;
  logic [15:0] src_info;
  logic [31:0] cur_pc, rd_a_data, rd_b_data;
  logic [4:0]  opcode;
  logic        irq_ack, fetch_go, pc_load, ie, wr_a_en, wr_b_en;
  logic [31:0] new_pc, wr_a_data, wr_b_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  intr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .fetch_start(fetch_start),
    .irq_req(irq_req), .src_type(src_type), .src_info(src_info),
    .cur_pc(cur_pc), .op_valid(op_valid), .opcode(opcode),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .irq_ack(irq_ack),
    .fetch_go(fetch_go), .pc_load(pc_load), .new_pc(new_pc), .ie(ie),
    .wr_a_en(wr_a_en), .wr_a_data(wr_a_data), .wr_b_en(wr_b_en),
    .wr_b_data(wr_b_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    run = 1'b1; fetch_start = 1'b0; irq_req = 1'b0; op_valid = 1'b0;
    opcode = '0; rd_a_data = '0; rd_b_data = '0;
  endtask

  // drive one op at negedge, return at next negedge with registered outputs visible
  task automatic do_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
    op_valid = 1'b1; opcode = op; rd_a_data = a; rd_b_data = b;
    @(negedge clk);
    idle();
  endtask

  task automatic check_saved(input string req, input logic [31:0] exp_a, input logic [31:0] exp_b);
    do_op(5'd16, '0, '0);
    chk({req, " save wr_a_en"}, {31'b0, wr_a_en}, 32'd1);
    chk({req, " save cause"}, wr_a_data, exp_a);
    chk({req, " save wr_b_en"}, {31'b0, wr_b_en}, 32'd1);
    chk({req, " save pc"}, wr_b_data, exp_b);
  endtask

  task automatic fetch_with_req(input logic r, input logic rn, input logic [31:0] pc,
                                input logic [7:0] ty, input logic [15:0] inf,
                                input logic expect_go);
    run = rn; fetch_start = 1'b1; irq_req = r; cur_pc = pc; src_type = ty; src_info = inf;
    #1;
    chk("R1/R2 fetch_go", {31'b0, fetch_go}, {31'b0, expect_go});
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R10 ie", {31'b0, ie}, 32'd0);
    chk("R10 ack", {31'b0, irq_ack}, 32'd0);
    chk("R10 pc_load", {31'b0, pc_load}, 32'd0);
    chk("R10 wr_a_en", {31'b0, wr_a_en}, 32'd0);
    chk("R10 wr_b_en", {31'b0, wr_b_en}, 32'd0);
    check_saved("R10", 32'h0, 32'h0);
  endtask

  task automatic t_masked();
    fetch_with_req(1'b1, 1'b1, 32'h100, 8'h11, 16'h2222, 1'b1);
    chk("R1 masked no ack", {31'b0, irq_ack}, 32'd0);
    do_op(5'd10, '0, '0);
    chk("R7 enable", {31'b0, ie}, 32'd1);
    fetch_with_req(1'b1, 1'b0, 32'h104, 8'h11, 16'h2222, 1'b0);
    chk("R1 not running no ack", {31'b0, irq_ack}, 32'd0);
    fetch_with_req(1'b0, 1'b1, 32'h108, 8'h11, 16'h2222, 1'b1);
    chk("R1 no request no ack", {31'b0, irq_ack}, 32'd0);
  endtask

  task automatic t_entry();
    fetch_with_req(1'b1, 1'b1, 32'h1234_5678, 8'hA5, 16'hBEEF, 1'b0);
    chk("R5 ack high", {31'b0, irq_ack}, 32'd1);
    chk("R4 pc_load", {31'b0, pc_load}, 32'd1);
    chk("R4 vector", new_pc, 32'h0000_0A50);
    chk("R3 ie cleared", {31'b0, ie}, 32'd0);
    @(negedge clk);
    chk("R5 ack low", {31'b0, irq_ack}, 32'd0);
    chk("R4 pc_load low", {31'b0, pc_load}, 32'd0);
    check_saved("R3/R8", 32'h0000_BEEF, 32'h1234_5678);
    fetch_with_req(1'b1, 1'b1, 32'h200, 8'h01, 16'h0001, 1'b1);
    chk("R1 masked after entry", {31'b0, irq_ack}, 32'd0);
  endtask

  task automatic t_restore_return();
    do_op(5'd17, 32'hFFFF_1357, 32'h00C0_FFEE);
    check_saved("R9", 32'h0000_1357, 32'h00C0_FFEE);
    irq_req = 1'b1;
    do_op(5'd29, '0, '0);
    chk("R6 pc_load", {31'b0, pc_load}, 32'd1);
    chk("R6 new_pc", new_pc, 32'h00C0_FFEE);
    chk("R6 ie set", {31'b0, ie}, 32'd1);
    chk("R6 not taken during return", {31'b0, irq_ack}, 32'd0);
    fetch_with_req(1'b1, 1'b1, 32'h00C0_FFEE, 8'hFF, 16'h7777, 1'b0);
    chk("R4 vector ff", new_pc, 32'h0000_0FF0);
    chk("R5 ack after return", {31'b0, irq_ack}, 32'd1);
  endtask

  task automatic t_disable_other();
    do_op(5'd10, '0, '0);
    do_op(5'd11, '0, '0);
    chk("R7 disable", {31'b0, ie}, 32'd0);
    do_op(5'd10, '0, '0);
    do_op(5'd5, 32'hAAAA_AAAA, 32'h5555_5555);
    chk("R12 ie kept", {31'b0, ie}, 32'd1);
    chk("R12 no pc_load", {31'b0, pc_load}, 32'd0);
    chk("R12 no write", {31'b0, wr_a_en | wr_b_en}, 32'd0);
    check_saved("R12", 32'h0000_7777, 32'h00C0_FFEE);
  endtask

  task automatic t_collision();
    run = 1'b1; fetch_start = 1'b1; irq_req = 1'b1; cur_pc = 32'h0000_4440;
    src_type = 8'h3C; src_info = 16'h4321;
    op_valid = 1'b1; opcode = 5'd17; rd_a_data = 32'h0000_9999; rd_b_data = 32'h8888_8888;
    @(negedge clk);
    idle();
    chk("R11 entry wins ack", {31'b0, irq_ack}, 32'd1);
    chk("R11 vector", new_pc, 32'h0000_03C0);
    chk("R11 ie", {31'b0, ie}, 32'd0);
    check_saved("R11", 32'h0000_4321, 32'h0000_4440);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle();
    cur_pc = '0; src_type = '0; src_info = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked();
    t_entry();
    t_restore_return();
    t_disable_other();
    t_collision();
    finish_run();
  end
endmodule